// File: doc/BRIEF.md
# DSSS preamble and header transmitter

This block builds the physical-layer framing of a direct-sequence spread-spectrum packet at the chip level. A start strobe launches a frame in one of two framing modes. Long mode is the legacy-compatible framing. Short mode trades that compatibility for a shorter overhead. The block emits a synchronization field, a 16-bit start frame delimiter and a 48-bit header, then pulls payload bytes from a valid/ready stream until the stream runs dry.

Every bit, including the fixed sync pattern, is passed through a self-synchronizing scrambler. The scrambled bits are then differentially encoded into a carrier phase, one bit per symbol (DBPSK) or two bits per symbol (DQPSK). Each symbol is spread over an 11-chip Barker word, with one chip per clock. The outputs are the I and Q chip signs, a chip-valid strobe and a code that names the field the current chip belongs to. A downstream modulator consumes these outputs.

Top module: `dsss_plcp_tx`

## Requirements
- R1: During and after reset, `chip_valid` and `pay_ready` are 0 and `frame_phase` is 0 (idle).
- R2: With `short_mode`=0 at start, the sync field is 128 symbols carrying logic 1 before scrambling, the scrambler state is seeded with 7'b1101100, and `frame_phase` reads 1.
- R3: With `short_mode`=1 at start, the sync field is 56 symbols carrying logic 0 before scrambling, the scrambler is seeded with 7'b0011011, and `frame_phase` reads 1.
- R4: The delimiter is 16 DBPSK symbols with `frame_phase`=2. Long mode sends 16'hF3A0 least significant bit first. Short mode sends the same word most significant bit first, which is the time reverse of the long order.
- R5: The header is the 48-bit word {crc, length, service, signal}, sent least significant bit first (bit 0 of `hdr_signal` goes first), with `frame_phase`=3. Long mode sends it DBPSK at one bit per symbol. Short mode sends it DQPSK at two bits per symbol, with the earlier bit first in the dibit. Sync, delimiter and header together last 192 symbols in long mode and 96 in short mode.
- R6: The scrambler state s[6:0] holds the seed at start. Each input bit b gives output o = b ^ s[3] ^ s[6], and then s becomes {s[5:0], o}. The state carries over from one field to the next.
- R7: The phase starts at 0 quarter turns at start. In DBPSK, a scrambled 1 adds two quarter turns. In DQPSK, the dibit (first, second) adds quarter turns as follows: 00 adds 0, 01 adds 1, 11 adds 2 and 10 adds 3. Phase 0/1/2/3 maps to the sign pair (I,Q) = (0,0)/(1,0)/(1,1)/(0,1), where a sign bit of 1 means negative.
- R8: Each symbol occupies 11 consecutive clocks with `chip_valid`=1. Chip k carries the symbol signs inverted for k in {1,4,8,9,10} and unchanged otherwise.
- R9: The clock after `start` is sampled in idle is a preparation cycle with `chip_valid`=0. The first chip appears in the clock after that.
- R10: `pay_rate_2m` is captured at start and selects one or two payload bits per symbol. Bytes are sent least significant bit first with `frame_phase`=4. `pay_ready` is high for one clock just before the first chip of each byte. If `pay_valid` is low in that clock, the frame ends: `chip_valid` and `frame_phase` return to 0 after the last chip.
- R11: A `start` pulse while a frame is in progress has no effect on the chip stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch a frame when idle |
| short_mode | input | 1 | 1 selects short framing, captured at start |
| pay_rate_2m | input | 1 | 1 selects two payload bits per symbol, captured at start |
| hdr_signal | input | 8 | Header signal field, captured at start |
| hdr_service | input | 8 | Header service field, captured at start |
| hdr_length | input | 16 | Header length field, captured at start |
| hdr_crc | input | 16 | Header check field, captured at start |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Payload byte taken this clock |
| chip_i | output | 1 | I chip sign, 1 = negative |
| chip_q | output | 1 | Q chip sign, 1 = negative |
| chip_valid | output | 1 | Chip outputs are valid |
| frame_phase | output | 3 | 0 idle, 1 sync, 2 delimiter, 3 header, 4 payload |

## Verification
Frames are run in both framing modes, crossed with both payload rates and with payloads of zero to four bytes. Each frame uses header words chosen to hold all-ones, all-zeros and mixed values. The all-ones and all-zeros headers expose the scrambler seed and the field ordering. The mixed values expose bit order and dibit-to-phase mapping errors that a symmetric pattern would hide. The chip stream is compared chip by chip against a model built from the requirements. A count of chips per field separates length errors from sign errors, and a stray start pulse placed mid-frame shows whether a running frame is disturbed.

// File: rtl/dsss_plcp_tx.sv
module dsss_plcp_tx #(
  parameter int LONG_SYNC  = 128,
  parameter int SHORT_SYNC = 56,
  parameter int SFD_LEN    = 16,
  parameter int HDR_LEN    = 48,
  parameter int CHIPS      = 11,
  parameter logic [SFD_LEN-1:0] SFD_WORD   = 16'hF3A0,
  parameter logic [6:0]         SEED_LONG  = 7'b1101100,
  parameter logic [6:0]         SEED_SHORT = 7'b0011011,
  parameter logic [CHIPS-1:0]   BARKER_NEG = 11'b11100010010
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        short_mode,
  input  logic        pay_rate_2m,
  input  logic [7:0]  hdr_signal,
  input  logic [7:0]  hdr_service,
  input  logic [15:0] hdr_length,
  input  logic [15:0] hdr_crc,
  input  logic [7:0]  pay_data,
  input  logic        pay_valid,
  output logic        pay_ready,
  output logic        chip_i,
  output logic        chip_q,
  output logic        chip_valid,
  output logic [2:0]  frame_phase
);
  localparam int MAXF = (LONG_SYNC > HDR_LEN) ? LONG_SYNC : HDR_LEN;
  localparam int BW   = $clog2(MAXF + 1);
  localparam int CW   = $clog2(CHIPS);

  typedef enum logic [2:0] {F_IDLE, F_SYNC, F_SFD, F_HDR, F_PAY} field_t;

  field_t st, fld;
  logic [BW-1:0]      bc;
  logic [CW-1:0]      cc;
  logic               pre, short_q, rate_q;
  logic [6:0]         scr;
  logic [1:0]         ph;
  logic [HDR_LEN-1:0] hdr_q;
  logic [7:0]         pbyte;
  logic [2:0]         pcnt;

  logic busy, fetch, two, ending, last_sync;
  logic b0, b1, s1, s2;
  logic [6:0] scr_a, scr_b;
  logic [1:0] inc, nb;
  logic [7:0] src;
  logic [SFD_LEN-1:0] sfd_fwd, sfd_rev;

  assign busy      = st != F_IDLE;
  assign fetch     = busy && (pre || cc == CW'(CHIPS - 1));
  assign two       = (st == F_HDR && short_q) || (st == F_PAY && rate_q);
  assign nb        = two ? 2'd2 : 2'd1;
  assign src       = (pcnt == 3'd0) ? pay_data : pbyte;
  assign sfd_fwd   = SFD_WORD >> bc;
  assign sfd_rev   = SFD_WORD << bc;
  assign ending    = st == F_PAY && pcnt == 3'd0 && !pay_valid;
  assign last_sync = bc == BW'((short_q ? SHORT_SYNC : LONG_SYNC) - 1);

  always_comb begin
    b0 = 1'b0;
    b1 = 1'b0;
    case (st)
      F_SYNC: begin b0 = ~short_q; b1 = ~short_q; end
      F_SFD:  b0 = short_q ? sfd_rev[SFD_LEN-1] : sfd_fwd[0];
      F_HDR:  begin b0 = hdr_q[0]; b1 = hdr_q[1]; end
      F_PAY:  begin b0 = src[0]; b1 = src[1]; end
      default: ;
    endcase
  end

  assign s1    = b0 ^ scr[3] ^ scr[6];
  assign scr_a = {scr[5:0], s1};
  assign s2    = b1 ^ scr_a[3] ^ scr_a[6];
  assign scr_b = {scr_a[5:0], s2};
  assign inc   = two ? {s1, s1 ^ s2} : {s1, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; fld <= F_IDLE; bc <= '0; cc <= '0; pre <= 1'b0;
      short_q <= 1'b0; rate_q <= 1'b0; scr <= '0; ph <= '0;
      hdr_q <= '0; pbyte <= '0; pcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        st      <= F_SYNC;
        bc      <= '0;
        cc      <= '0;
        pre     <= 1'b1;
        short_q <= short_mode;
        rate_q  <= pay_rate_2m;
        scr     <= short_mode ? SEED_SHORT : SEED_LONG;
        ph      <= '0;
        hdr_q   <= HDR_LEN'({hdr_crc, hdr_length, hdr_service, hdr_signal});
        pcnt    <= '0;
      end
    end else if (fetch) begin
      cc  <= '0;
      pre <= 1'b0;
      if (ending) begin
        st  <= F_IDLE;
        fld <= F_IDLE;
      end else begin
        fld <= st;
        ph  <= ph + inc;
        scr <= two ? scr_b : scr_a;
        case (st)
          F_SYNC: if (last_sync) begin st <= F_SFD; bc <= '0; end
                  else bc <= bc + BW'(1);
          F_SFD:  if (bc == BW'(SFD_LEN - 1)) begin st <= F_HDR; bc <= '0; end
                  else bc <= bc + BW'(1);
          F_HDR: begin
            hdr_q <= hdr_q >> nb;
            if (bc + BW'(nb) == BW'(HDR_LEN)) begin st <= F_PAY; bc <= '0; pcnt <= '0; end
            else bc <= bc + BW'(nb);
          end
          F_PAY: begin
            pbyte <= src >> nb;
            pcnt  <= pcnt + 3'(nb);
          end
          default: ;
        endcase
      end
    end else begin
      cc <= cc + CW'(1);
    end
  end

  assign pay_ready   = fetch && st == F_PAY && pcnt == 3'd0;
  assign chip_valid  = fld != F_IDLE;
  assign frame_phase = fld;
  assign chip_i      = (ph[1] ^ ph[0]) ^ BARKER_NEG[cc];
  assign chip_q      = ph[1] ^ BARKER_NEG[cc];

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frame_phase == 3'd0 |-> !chip_valid);

  a_r9_prep_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> !chip_valid ##1 chip_valid);

  a_r7_long_even_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !short_q && frame_phase != 3'd4) |-> !ph[0]);

  a_r5_field_order: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && $past(chip_valid) && frame_phase != $past(frame_phase))
      |-> frame_phase == $past(frame_phase) + 3'd1);

  a_r10_byte_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && pay_valid) |=> (chip_valid && frame_phase == 3'd4));

  a_r10_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && !pay_valid) |=> (!chip_valid && frame_phase == 3'd0));

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fetch) |=> ($stable(scr) && !pre));
endmodule

// File: tb/test_dsss_plcp_tx.sv
`timescale 1ns/1ps
module test_dsss_plcp_tx;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, short_mode = 1'b0, pay_rate_2m = 1'b0;
  logic [7:0] hdr_signal = '0, hdr_service = '0;
  logic [15:0] hdr_length = '0, hdr_crc = '0;
  logic [7:0] pay_data;
  logic pay_valid, pay_ready, chip_i, chip_q, chip_valid;
  logic [2:0] frame_phase;

  int tests = 0, fails = 0;
  int idx = 0, npay = 0;
  bit act_pay = 0;

  always #2.5 clk = ~clk;

  assign pay_valid = act_pay && (idx < npay);
  assign pay_data  = 8'(idx * 73 + 29);
  always @(posedge clk) if (pay_ready && pay_valid) idx <= idx + 1;

  dsss_plcp_tx i_dsss_plcp_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .short_mode(short_mode),
    .pay_rate_2m(pay_rate_2m), .hdr_signal(hdr_signal), .hdr_service(hdr_service),
    .hdr_length(hdr_length), .hdr_crc(hdr_crc), .pay_data(pay_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .chip_i(chip_i), .chip_q(chip_q),
    .chip_valid(chip_valid), .frame_phase(frame_phase));

  // {short, rate2, npay[2:0], signal, service, length, crc}
  localparam logic [52:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd2, 8'h0A, 8'h00, 16'h1234, 16'hBEEF},
    {1'b1, 1'b1, 3'd3, 8'h14, 8'h04, 16'h0040, 16'h5A5A},
    {1'b0, 1'b1, 3'd1, 8'h6E, 8'h80, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 3'd0, 8'h37, 8'h00, 16'h0001, 16'hA5C3},
    {1'b0, 1'b0, 3'd0, 8'hFF, 8'hFF, 16'h0000, 16'hFFFF},
    {1'b1, 1'b1, 3'd4, 8'h00, 8'h00, 16'h0000, 16'h0000}
  };
  localparam logic [10:0] BN = 11'b11100010010; // R8: chips 1,4,8,9,10 inverted
  localparam logic [15:0] SFDW = 16'hF3A0;

  logic [6:0] ms;
  logic [1:0] mp;
  int mn;
  bit e_i [0:3999];
  bit e_q [0:3999];
  logic [2:0] e_f [0:3999];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit scram(input bit b);
    bit o;
    o = b ^ ms[3] ^ ms[6];
    ms = {ms[5:0], o};
    return o;
  endfunction

  task automatic emit(input bit b0, input bit b1, input bit two, input logic [2:0] f);
    bit o1, o2, si, sq;
    o1 = scram(b0);
    if (two) begin
      o2 = scram(b1);
      case ({o1, o2})
        2'b00: mp = mp + 2'd0;
        2'b01: mp = mp + 2'd1;
        2'b11: mp = mp + 2'd2;
        default: mp = mp + 2'd3;
      endcase
    end else if (o1) mp = mp + 2'd2;
    case (mp)
      2'd0: begin si = 0; sq = 0; end
      2'd1: begin si = 1; sq = 0; end
      2'd2: begin si = 1; sq = 1; end
      default: begin si = 0; sq = 1; end
    endcase
    for (int c = 0; c < 11; c++) begin
      e_i[mn] = si ^ BN[c];
      e_q[mn] = sq ^ BN[c];
      e_f[mn] = f;
      mn++;
    end
  endtask

  task automatic gen(input logic [52:0] v);
    bit sh, r2;
    logic [47:0] hd;
    logic [7:0] by;
    sh = v[52]; r2 = v[51];
    hd = {v[15:0], v[31:16], v[39:32], v[47:40]};
    ms = sh ? 7'b0011011 : 7'b1101100;
    mp = 2'd0; mn = 0;
    for (int k = 0; k < (sh ? 56 : 128); k++) emit(!sh, !sh, 0, 3'd1);
    for (int k = 0; k < 16; k++) emit(sh ? SFDW[15-k] : SFDW[k], 0, 0, 3'd2);
    if (sh) for (int k = 0; k < 24; k++) emit(hd[2*k], hd[2*k+1], 1, 3'd3);
    else    for (int k = 0; k < 48; k++) emit(hd[k], 0, 0, 3'd3);
    for (int b = 0; b < int'(v[50:48]); b++) begin
      by = 8'(b * 73 + 29);
      if (r2) for (int k = 0; k < 4; k++) emit(by[2*k], by[2*k+1], 1, 3'd4);
      else    for (int k = 0; k < 8; k++) emit(by[k], 0, 0, 3'd4);
    end
  endtask

  task automatic run_frame(input logic [52:0] v, input bit glitch);
    int cnt [5];
    int got, mism, cyc;
    bit seen;
    bit sh;
    int per;
    sh = v[52];
    short_mode = v[52]; pay_rate_2m = v[51];
    hdr_signal = v[47:40]; hdr_service = v[39:32]; hdr_length = v[31:16]; hdr_crc = v[15:0];
    idx = 0; npay = int'(v[50:48]); act_pay = 1;
    gen(v);
    foreach (cnt[j]) cnt[j] = 0;
    got = 0; mism = 0; cyc = 0; seen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(chip_valid == 1'b0, "R9 prep cycle", int'(chip_valid), 0);
    @(negedge clk);
    chk(chip_valid == 1'b1, "R9 first chip", int'(chip_valid), 1);
    while (cyc < 4000) begin
      if (chip_valid) begin
        seen = 1;
        if (got < mn) begin
          if (chip_i != e_i[got] || chip_q != e_q[got] || frame_phase != e_f[got]) mism++;
        end else mism++;
        if (frame_phase < 3'd5) cnt[frame_phase]++;
        got++;
      end else if (seen) break;
      if (glitch) start = (cyc == 300 || cyc == 1500);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    act_pay = 0;
    chk(mism == 0, "R6 R7 R8 chip stream", mism, 0);
    chk(got == mn, "R8 total chips", got, mn);
    chk(cnt[1] == (sh ? 56 : 128) * 11, sh ? "R3 sync length" : "R2 sync length",
        cnt[1], (sh ? 56 : 128) * 11);
    chk(cnt[2] == 176, "R4 delimiter length", cnt[2], 176);
    chk(cnt[3] == (sh ? 24 : 48) * 11, "R5 header length", cnt[3], (sh ? 24 : 48) * 11);
    chk(cnt[1] + cnt[2] + cnt[3] == (sh ? 96 : 192) * 11, "R5 preamble plus header",
        cnt[1] + cnt[2] + cnt[3], (sh ? 96 : 192) * 11);
    per = v[51] ? 4 : 8;
    chk(cnt[4] == npay * per * 11, "R10 payload length", cnt[4], npay * per * 11);
    chk(idx == npay, "R10 bytes accepted", idx, npay);
    chk(frame_phase == 3'd0 && !pay_ready, "R10 frame end idle", int'(frame_phase), 0);
    if (glitch) chk(mism == 0 && got == mn, "R11 start ignored", mism, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(!chip_valid && !pay_ready && frame_phase == 3'd0, "R1 in reset", int'(frame_phase), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!chip_valid && !pay_ready && frame_phase == 3'd0, "R1 after reset", int'(chip_valid), 0);
    foreach (VEC[n]) run_frame(VEC[n], 1'b0);
    run_frame(VEC[0], 1'b1);
    run_frame(VEC[1], 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule